// File: doc/BRIEF.md
# Field-Sync Layer Descriptor Loader

This block is the control front end of one graphics overlay layer. It holds the register set that describes the layer: control word, alpha gain, viewport origin and stop, pixel buffer address, line pitch, size, two color keys, layer properties and palette address. Software does not normally write these registers one by one. It builds descriptors in memory, one per field, each 16 words long and laid out exactly like the register file, and points the block at the first one. On every field sync the block walks the next-node pointer, reads the 16 words over a word-read request/response port into a staging buffer, and only once all words have arrived does it swap them into the visible registers in a single cycle.

Each descriptor carries its own next-node pointer, so two descriptors that point at each other alternate forever, one per field. A zero pointer stops the chain and hides the layer. A pointer that is not 16-byte aligned is refused with an error flag. A sync that arrives while a fetch is still running is counted as missed, and the fetch carries on. A CPU port reads any register and writes it directly; a write to the next-node word only steers the next sync.

Downstream pixel logic receives the active descriptor fields, decoded width, height and format, a field (top/bottom) indication and a layer-visible flag.

Top module: `layer_desc_fetch`

## Requirements
- R1: After reset every descriptor register reads 0, the field output shows top (0), layer_visible_o, align_err_o and mem_req_o are low and the missed-sync count is 0.
- R2: At a sync (rising edge of vsync_i) with a nonzero, 16-byte-aligned next-node value, the block issues 16 single-word reads at byte addresses base+4*k for k = 0..15, one outstanding at a time, and updates all visible registers together only after word 15 has arrived; until then the previous values stay on the outputs.
- R3: Word index k of a descriptor loads register index k; the loaded word 9 becomes the next-node register, so two descriptors that point to each other alternate on successive syncs.
- R4: A CPU write to register index 9 (next-node) changes no output and starts no read until the next sync, and reads back at once on cpu_rdata_o.
- R5: At a sync with a next-node value of 0 the block issues no read and layer_visible_o goes low; the other registers keep their values.
- R6: At a sync with next-node bits 3:0 nonzero the block issues no read, sets align_err_o and hides the layer; align_err_o clears at the next sync that finds a usable pointer.
- R7: A sync that arrives while a fetch is running, including the cycle its result is committed, increments missed_cnt_o by one and does not disturb the fetch in flight.
- R8: layer_visible_o is high only after a descriptor has been committed and while properties (index 13) bits 1:0 are not both 1.
- R9: With interlace_i high each sync toggles field_bottom_o (0 = top, 1 = bottom), starting at top after reset; with interlace_i low each sync forces it to top.
- R10: width_o is size (index 7) bits 10:0, height_o is size bits 26:16, pix_fmt_o is control (index 0) bits 4:0, alpha_full_o is control bit 5 and wait_sync_o is control bit 31.
- R11: A CPU write to any other register index updates that register and its output on the next cycle; indices 2, 8, 12 and 14 are reserved, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Field sync; rising edge starts a field |
| interlace_i | input | 1 | 1 = interlaced field alternation |
| cpu_we_i | input | 1 | CPU register write strobe |
| cpu_idx_i | input | 4 | CPU register word index |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rdata_o | output | 32 | CPU read data of the indexed register |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| field_bottom_o | output | 1 | Current field, 0 top, 1 bottom |
| layer_visible_o | output | 1 | Layer is shown by the mixer |
| align_err_o | output | 1 | Last sync met an unaligned pointer |
| missed_cnt_o | output | 8 | Count of syncs that hit a running fetch |
| ctrl_o | output | 32 | Control register |
| pix_fmt_o | output | 5 | Pixel format code |
| alpha_full_o | output | 1 | Full 0..255 alpha range |
| wait_sync_o | output | 1 | Descriptor waits for the next sync |
| alpha_gain_o | output | 32 | Alpha gain register |
| vp_origin_o | output | 32 | Viewport origin, line in 31:16, pixel in 15:0 |
| vp_stop_o | output | 32 | Inclusive viewport stop, same packing |
| pix_addr_o | output | 32 | Pixel buffer address |
| pitch_o | output | 32 | Line pitch in bytes |
| width_o | output | 11 | Source width |
| height_o | output | 11 | Source height |
| key1_o | output | 32 | Color key 1 |
| key2_o | output | 32 | Color key 2 |
| props_o | output | 32 | Layer properties |
| palette_o | output | 32 | Palette address |

## Verification
The collision that matters is a field sync landing on a descriptor fetch, above all in the very cycle the staged words are committed. The bench raises a second sync a few cycles into a fetch and again exactly on the commit cycle, counted from the fixed response latency of its memory model. It judges that the missed count rises by one each time, that the registers end up holding the descriptor already in flight, and that the following sync continues the chain from that descriptor's own pointer.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 16;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  // register word indices (descriptor image maps onto them one-to-one)
  localparam int unsigned IX_CTRL = 0;
  localparam int unsigned IX_AGC  = 1;
  localparam int unsigned IX_VPO  = 3;
  localparam int unsigned IX_VPS  = 4;
  localparam int unsigned IX_PIX  = 5;
  localparam int unsigned IX_PMP  = 6;
  localparam int unsigned IX_SIZE = 7;
  localparam int unsigned IX_NEXT = 9;
  localparam int unsigned IX_KEY1 = 10;
  localparam int unsigned IX_KEY2 = 11;
  localparam int unsigned IX_PROP = 13;
  localparam int unsigned IX_PAL  = 15;

  // words 2, 8, 12, 14 hold no register
  localparam logic [DESC_WORDS-1:0] RSVD_MASK = 16'h5104;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT} fetch_state_e;
endpackage

// File: rtl/ldf_fetch.sv
module ldf_fetch
  import ldf_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic [WORD_W-1:0]                   base_i,
  output logic                                mem_req_o,
  output logic [WORD_W-1:0]                   mem_addr_o,
  input  logic                                mem_rvalid_i,
  input  logic [WORD_W-1:0]                   mem_rdata_i,
  output logic                                busy_o,
  output logic                                done_o,
  output logic [DESC_WORDS-1:0][WORD_W-1:0]   image_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  fetch_state_e                      state_q;
  logic [IDX_W-1:0]                  idx_q;
  logic [WORD_W-1:0]                 base_q;
  logic                              done_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FS_IDLE: if (start_i) begin
          base_q  <= base_i;
          idx_q   <= '0;
          state_q <= FS_REQ;
        end
        FS_REQ:  state_q <= FS_WAIT;
        FS_WAIT: if (mem_rvalid_i) begin
          stage_q[idx_q] <= mem_rdata_i;
          if (idx_q == LAST_IDX) begin
            state_q <= FS_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= FS_REQ;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == FS_REQ);
  assign mem_addr_o = base_q + WORD_W'({idx_q, 2'b00});
  // commit cycle still counts as busy so a colliding sync is missed
  assign busy_o     = (state_q != FS_IDLE) || done_q;
  assign done_o     = done_q;
  assign image_o    = stage_q;

  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_done_after_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rvalid_i));
  p_start_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/ldf_regs.sv
module ldf_regs
  import ldf_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                commit_i,
  input  logic [DESC_WORDS-1:0][WORD_W-1:0]   image_i,
  input  logic                                cpu_we_i,
  input  logic [IDX_W-1:0]                    cpu_idx_i,
  input  logic [WORD_W-1:0]                   cpu_wdata_i,
  output logic [WORD_W-1:0]                   cpu_rdata_o,
  output logic [DESC_WORDS-1:0][WORD_W-1:0]   words_o
);
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    if (RSVD_MASK[g]) begin : g_rsvd
      logic unused_word;
      assign unused_word = ^image_i[g];
      assign words_o[g]  = '0;
    end else begin : g_reg
      logic [WORD_W-1:0] q;
      // CPU write wins over a commit in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    q <= '0;
        else if (cpu_we_i && cpu_idx_i == IDX_W'(g))    q <= cpu_wdata_i;
        else if (commit_i)                              q <= image_i[g];
      end
      assign words_o[g] = q;
    end
  end

  assign cpu_rdata_o = words_o[cpu_idx_i];

  p_hold_between_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i && !cpu_we_i |=> $stable(words_o));
  p_commit_takes_image_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !cpu_we_i |=> words_o[IX_NEXT] == $past(image_i[IX_NEXT]));
endmodule

// File: rtl/layer_desc_fetch.sv
module layer_desc_fetch
  import ldf_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vsync_i,
  input  logic               interlace_i,
  input  logic               cpu_we_i,
  input  logic [IDX_W-1:0]   cpu_idx_i,
  input  logic [WORD_W-1:0]  cpu_wdata_i,
  output logic [WORD_W-1:0]  cpu_rdata_o,
  output logic               mem_req_o,
  output logic [WORD_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               field_bottom_o,
  output logic               layer_visible_o,
  output logic               align_err_o,
  output logic [CNT_W-1:0]   missed_cnt_o,
  output logic [WORD_W-1:0]  ctrl_o,
  output logic [4:0]         pix_fmt_o,
  output logic               alpha_full_o,
  output logic               wait_sync_o,
  output logic [WORD_W-1:0]  alpha_gain_o,
  output logic [WORD_W-1:0]  vp_origin_o,
  output logic [WORD_W-1:0]  vp_stop_o,
  output logic [WORD_W-1:0]  pix_addr_o,
  output logic [WORD_W-1:0]  pitch_o,
  output logic [10:0]        width_o,
  output logic [10:0]        height_o,
  output logic [WORD_W-1:0]  key1_o,
  output logic [WORD_W-1:0]  key2_o,
  output logic [WORD_W-1:0]  props_o,
  output logic [WORD_W-1:0]  palette_o
);
  logic [DESC_WORDS-1:0][WORD_W-1:0] words, image;
  logic sync_q, sync, busy, done, start;
  logic ptr_null, ptr_misaligned;
  logic field_q, err_q, loaded_q;
  logic [CNT_W-1:0] missed_q;
  logic [WORD_W-1:0] next_ptr;

  assign sync           = vsync_i & ~sync_q;
  assign next_ptr       = words[IX_NEXT];
  assign ptr_null       = (next_ptr == '0);
  assign ptr_misaligned = |next_ptr[3:0];
  assign start          = sync & ~busy & ~ptr_null & ~ptr_misaligned;

  ldf_fetch u_fetch (
    .clk_i, .rst_ni,
    .start_i      (start),
    .base_i       (next_ptr),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .busy_o       (busy),
    .done_o       (done),
    .image_o      (image)
  );

  ldf_regs u_regs (
    .clk_i, .rst_ni,
    .commit_i     (done),
    .image_i      (image),
    .cpu_we_i, .cpu_idx_i, .cpu_wdata_i, .cpu_rdata_o,
    .words_o      (words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      field_q  <= 1'b0;
      err_q    <= 1'b0;
      loaded_q <= 1'b0;
      missed_q <= '0;
    end else begin
      sync_q <= vsync_i;
      if (sync) field_q <= interlace_i ? ~field_q : 1'b0;
      if (sync && busy) begin
        missed_q <= missed_q + 1'b1;
      end else if (sync) begin
        err_q <= ~ptr_null & ptr_misaligned;
        if (ptr_null || ptr_misaligned) loaded_q <= 1'b0;
      end
      if (done) loaded_q <= 1'b1;
    end
  end

  assign field_bottom_o  = field_q;
  assign align_err_o     = err_q;
  assign missed_cnt_o    = missed_q;
  assign layer_visible_o = loaded_q & (words[IX_PROP][1:0] != 2'b11);

  assign ctrl_o       = words[IX_CTRL];
  assign pix_fmt_o    = words[IX_CTRL][4:0];
  assign alpha_full_o = words[IX_CTRL][5];
  assign wait_sync_o  = words[IX_CTRL][31];
  assign alpha_gain_o = words[IX_AGC];
  assign vp_origin_o  = words[IX_VPO];
  assign vp_stop_o    = words[IX_VPS];
  assign pix_addr_o   = words[IX_PIX];
  assign pitch_o      = words[IX_PMP];
  assign width_o      = words[IX_SIZE][10:0];
  assign height_o     = words[IX_SIZE][26:16];
  assign key1_o       = words[IX_KEY1];
  assign key2_o       = words[IX_KEY2];
  assign props_o      = words[IX_PROP];
  assign palette_o    = words[IX_PAL];

  p_first_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> mem_req_o && mem_addr_o == $past(next_ptr));
  p_null_no_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync && !busy && ptr_null |=> !mem_req_o && !layer_visible_o);
  p_misaligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync && !busy && ptr_misaligned |=> align_err_o && !mem_req_o && !layer_visible_o);
  p_missed_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync && busy |=> missed_cnt_o == CNT_W'($past(missed_cnt_o) + 1'b1));
  p_prog_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync && !interlace_i |=> !field_bottom_o);
  p_field_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync && interlace_i |=> field_bottom_o != $past(field_bottom_o));
  p_hidden_props_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    props_o[1:0] == 2'b11 |-> !layer_visible_o);
endmodule

// File: tb/tb_layer_desc_fetch.sv
module tb_layer_desc_fetch;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vsync = 1'b0, interlace = 1'b0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_idx = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        field_bottom, visible, align_err, alpha_full, wait_sync;
  logic [7:0]  missed;
  logic [4:0]  pix_fmt;
  logic [10:0] width, height;
  logic [31:0] ctrl, agc, vpo, vps, pix, pitch, key1, key2, props, pal;

  always #10 clk = ~clk;

  layer_desc_fetch dut (
    .clk_i(clk), .rst_ni, .vsync_i(vsync), .interlace_i(interlace),
    .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .field_bottom_o(field_bottom), .layer_visible_o(visible), .align_err_o(align_err),
    .missed_cnt_o(missed), .ctrl_o(ctrl), .pix_fmt_o(pix_fmt), .alpha_full_o(alpha_full),
    .wait_sync_o(wait_sync), .alpha_gain_o(agc), .vp_origin_o(vpo), .vp_stop_o(vps),
    .pix_addr_o(pix), .pitch_o(pitch), .width_o(width), .height_o(height),
    .key1_o(key1), .key2_o(key2), .props_o(props), .palette_o(pal)
  );

  logic [31:0] mem [0:63];
  logic [31:0] shown [16];
  logic        shown_loaded = 1'b0;
  logic        exp_field = 1'b0;
  int          n_checks = 0, n_fail = 0, req_cnt = 0, exp_req = 0, addr_bad = 0, word_k = 0;
  int          exp_missed = 0;
  logic [31:0] exp_base = '0;
  logic        done_flag = 1'b0;

  // memory model: one-cycle response latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[7:2]];
    if (mem_req) begin
      if (mem_addr !== exp_base + 32'(word_k * 4)) addr_bad++;
      word_k++;
      req_cnt++;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sync();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    exp_field = interlace ? ~exp_field : 1'b0;
  endtask

  task automatic cpu_write(input int idx, input logic [31:0] d);
    cpu_we = 1'b1; cpu_idx = 4'(idx); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input int idx, output logic [31:0] d);
    cpu_idx = 4'(idx);
    #1 d = cpu_rdata;
  endtask

  task automatic fill(input int b, input logic [31:0] nxt, input logic [1:0] pr);
    for (int k = 0; k < 16; k++) mem[b+k] = $urandom;
    mem[b+9]  = nxt;
    mem[b+13] = {mem[b+13][31:2], pr};
  endtask

  function automatic logic [31:0] rsv(input int k, input logic [31:0] v);
    return (k == 2 || k == 8 || k == 12 || k == 14) ? 32'h0 : v;
  endfunction

  task automatic expect_load(input logic [31:0] base);
    for (int k = 0; k < 16; k++) shown[k] = rsv(k, mem[base[7:2] + 6'(k)]);
    shown_loaded = 1'b1;
    exp_req += 16;
  endtask

  task automatic arm(input logic [31:0] base);
    exp_base = base; word_k = 0;
  endtask

  task automatic check_shown(input string tag);
    logic [31:0] rd;
    chk({tag, " ctrl"}, ctrl, shown[0]);
    chk({tag, " alpha gain"}, agc, shown[1]);
    chk({tag, " vp origin"}, vpo, shown[3]);
    chk({tag, " vp stop"}, vps, shown[4]);
    chk({tag, " pix addr"}, pix, shown[5]);
    chk({tag, " pitch"}, pitch, shown[6]);
    chk({tag, " key1"}, key1, shown[10]);
    chk({tag, " key2"}, key2, shown[11]);
    chk({tag, " props"}, props, shown[13]);
    chk({tag, " palette"}, pal, shown[15]);
    chk({tag, " R10 width"}, 32'(width), 32'(shown[7][10:0]));
    chk({tag, " R10 height"}, 32'(height), 32'(shown[7][26:16]));
    chk({tag, " R10 fmt"}, 32'(pix_fmt), 32'(shown[0][4:0]));
    chk({tag, " R10 alpha range"}, 32'(alpha_full), 32'(shown[0][5]));
    chk({tag, " R10 wait sync"}, 32'(wait_sync), 32'(shown[0][31]));
    chk({tag, " R8 visible"}, 32'(visible), 32'(shown_loaded && shown[13][1:0] != 2'b11));
    cpu_read(9, rd);
    chk({tag, " R3 next-node"}, rd, shown[9]);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] tgt;
    void'($urandom(32'd1234));
    for (int k = 0; k < 64; k++) mem[k] = '0;
    for (int k = 0; k < 16; k++) shown[k] = '0;
    wait_cycles(3);
    rst_ni = 1'b1;
    wait_cycles(2);

    // R1 reset state
    chk("R1 ctrl", ctrl, 32'h0);
    chk("R1 visible", 32'(visible), 32'h0);
    chk("R1 field", 32'(field_bottom), 32'h0);
    chk("R1 align err", 32'(align_err), 32'h0);
    chk("R1 missed", 32'(missed), 32'h0);
    chk("R1 req", 32'(mem_req), 32'h0);
    cpu_read(9, rd);
    chk("R1 next-node", rd, 32'h0);

    // R5 null pointer
    pulse_sync(); wait_cycles(10);
    chk("R5 no read", 32'(req_cnt), 32'(exp_req));
    chk("R5 hidden", 32'(visible), 32'h0);

    // R4 / R6 unaligned pointer
    cpu_write(9, 32'h44);
    cpu_read(9, rd);
    chk("R4 readback", rd, 32'h44);
    wait_cycles(3);
    chk("R4 no read before sync", 32'(req_cnt), 32'(exp_req));
    pulse_sync(); wait_cycles(10);
    chk("R6 error set", 32'(align_err), 32'h1);
    chk("R6 no read", 32'(req_cnt), 32'(exp_req));
    chk("R6 hidden", 32'(visible), 32'h0);

    // R2 first load of a linked pair
    fill(16, 32'h80, 2'b00);
    fill(32, 32'h40, 2'b01);
    cpu_write(9, 32'h40);
    interlace = 1'b1;
    arm(32'h40);
    pulse_sync(); wait_cycles(20);
    chk("R2 atomic ctrl held", ctrl, 32'h0);
    chk("R2 atomic key1 held", key1, 32'h0);
    wait_cycles(20);
    expect_load(32'h40);
    check_shown("R2");
    chk("R6 error cleared", 32'(align_err), 32'h0);
    chk("R9 field bottom", 32'(field_bottom), 32'(exp_field));
    chk("R2 read count", 32'(req_cnt), 32'(exp_req));
    chk("R2 addresses", 32'(addr_bad), 32'h0);

    // R3 / R8 / R9 chain alternation with random content
    for (int i = 0; i < 6; i++) begin
      tgt = shown[9];
      fill(int'(tgt[7:2]), (tgt == 32'h40) ? 32'h80 : 32'h40, 2'(i % 4));
      arm(tgt);
      pulse_sync(); wait_cycles(40);
      expect_load(tgt);
      check_shown("R3");
      chk("R9 field toggles", 32'(field_bottom), 32'(exp_field));
      chk("R2 addresses", 32'(addr_bad), 32'h0);
    end

    // R7 sync a few cycles into a fetch
    tgt = shown[9];
    fill(int'(tgt[7:2]), (tgt == 32'h40) ? 32'h80 : 32'h40, 2'b00);
    arm(tgt);
    pulse_sync(); wait_cycles(5);
    pulse_sync(); exp_missed++;
    wait_cycles(40);
    expect_load(tgt);
    chk("R7 missed count", 32'(missed), 32'(exp_missed));
    check_shown("R7");
    chk("R7 field", 32'(field_bottom), 32'(exp_field));

    // R7 sync on the commit cycle
    tgt = shown[9];
    fill(int'(tgt[7:2]), (tgt == 32'h40) ? 32'h80 : 32'h40, 2'b10);
    arm(tgt);
    pulse_sync(); wait_cycles(32);
    pulse_sync(); exp_missed++;
    wait_cycles(40);
    expect_load(tgt);
    chk("R7 commit collision missed", 32'(missed), 32'(exp_missed));
    check_shown("R7");
    chk("R7 read count", 32'(req_cnt), 32'(exp_req));

    // R11 direct CPU access, reserved word
    cpu_write(10, 32'hDEADBEEF);
    chk("R11 key1 out", key1, 32'hDEADBEEF);
    cpu_read(10, rd);
    chk("R11 key1 readback", rd, 32'hDEADBEEF);
    cpu_write(2, 32'h12345678);
    cpu_read(2, rd);
    chk("R11 reserved reads zero", rd, 32'h0);
    cpu_write(13, 32'h3);
    chk("R8 ignore bits hide", 32'(visible), 32'h0);
    cpu_write(13, 32'h2);
    chk("R8 one bit keeps shown", 32'(visible), 32'h1);
    shown[10] = 32'hDEADBEEF; shown[13] = 32'h2;

    // R9 progressive
    interlace = 1'b0;
    for (int i = 0; i < 2; i++) begin
      tgt = shown[9];
      arm(tgt);
      pulse_sync(); wait_cycles(40);
      expect_load(tgt);
      chk("R9 progressive top", 32'(field_bottom), 32'h0);
      check_shown("R3");
    end

    // R4 / R5 stop the chain
    cpu_write(9, 32'h0);
    wait_cycles(3);
    chk("R4 still visible", 32'(visible), 32'(shown[13][1:0] != 2'b11));
    pulse_sync(); wait_cycles(10);
    chk("R5 hidden after null", 32'(visible), 32'h0);
    chk("R5 no read", 32'(req_cnt), 32'(exp_req));
    chk("R5 registers kept", ctrl, shown[0]);

    summary();
  end
endmodule